// File: doc/BRIEF.md
# Reset Sequencer with Source Detection

This block sequences the reset of a small microcontroller core. After power comes up, it holds the core in reset for a fixed stabilisation count. It also waits for the external reset pad to go high. During normal running it watches three reset sources: a watchdog request, a clock-monitor request, and the active-low reset pad itself.

When any of these sources fires, the block pulls the pad low for a fixed number of clock cycles and then lets go. A fixed number of cycles after letting go, it looks at the pad again. If something outside still holds the pad low, the reset is counted as external. If the pad has come back high, the reset is counted as internal, and the recorded source (watchdog or clock monitor) names it.

The pad is modelled as a drive-low enable plus a raw input level. The raw level passes through a flop synchroniser before the block looks at it. The core reset is a registered output, so it changes only on a clock edge. The last reset cause is kept as a one-hot vector until the next reset is classified. The power-on pulse acts as the block's own asynchronous reset.

Top module: `rst_seq`

## Requirements
- R1: After `por_i` falls, `core_rst_o` stays 1 through `POR_CYCLES` rising edges and is 0 after edge `POR_CYCLES`, provided the pad is high. The cause after power-on is bit 0 (value 4'b0001).
- R2: If the pad is still low when the power-on count ends, `core_rst_o` stays 1 until the synchronised pad reads high. It then falls at the next edge, which is `SYNC_STAGES`+1 edges after the raw pad rises.
- R3: Watchdog and clock-monitor requests during the power-on count are ignored. The release edge and the power-on cause are unchanged.
- R4: A request sampled at a rising edge while running raises `core_rst_o` after that edge. `pad_drive_low_o` is 1 for exactly `DRIVE_CYCLES` cycles starting after that same edge.
- R5: After release of the pad, the synchronised pad is examined `SAMPLE_GAP` cycles later. With the pad free, the core leaves reset `DRIVE_CYCLES`+`SAMPLE_GAP`+1 edges after the request edge (7 with defaults).
- R6: An internal reset with the pad high at the sample is classified as watchdog (bit 2, 4'b0100) or clock monitor (bit 3, 4'b1000). When both request together, the watchdog wins.
- R7: A low level on the raw pad while running starts the sequence 3 edges after the pad falls, and the cause is external (bit 1, 4'b0010). For a pad low during L cycles, the core leaves reset max(10, L+3) edges after the pad fell.
- R8: A watchdog or clock-monitor request sampled during the drive, gap or sample phases restarts the sequence from the drive phase. The recorded internal source is replaced by the new one, and the release then comes 7 edges after the restarting edge.
- R9: Requests while waiting for the pad to go high after an external classification are ignored. The release timing and the external cause are unchanged.
- R10: `cause_o` is always one-hot and does not change while the core is out of reset.

Parameters: `POR_CYCLES` (4064), `DRIVE_CYCLES` (4), `SAMPLE_GAP` (2), `SYNC_STAGES` (2).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal bus clock |
| por_i | input | 1 | Power-on pulse, active high, asynchronous block reset |
| wdog_req_i | input | 1 | Watchdog reset request, one-cycle pulse |
| cmon_req_i | input | 1 | Clock-monitor reset request, one-cycle pulse |
| pad_in_i | input | 1 | Raw level of the active-low reset pad |
| pad_drive_low_o | output | 1 | Enable that pulls the reset pad low |
| core_rst_o | output | 1 | Synchronous core reset, active high |
| cause_o | output | 4 | One-hot last reset cause: 0 power-on, 1 external, 2 watchdog, 3 clock monitor |

## Verification
The bench models the pad as pulled low by either the block's own drive or an external holder. It sweeps the external holder's low time from one cycle up to well past the sampling point. The short pulses separate sample-high from sample-low, and the long pulses separate a single classification from a wait for the pad to go high.

A second request is injected at every cycle offset across the drive, gap and sample phases. This tells a true restart apart from a request that is dropped or merged. Power-on runs are tried with the pad free, with the pad held past the count, and with requests inside the count. Single, paired and clock-monitor-only internal requests check the source priority.

// File: rtl/rst_seq_pkg.sv
package rst_seq_pkg;

    localparam int CAUSE_W    = 4;
    localparam int CAUSE_POR  = 0;
    localparam int CAUSE_EXT  = 1;
    localparam int CAUSE_WDOG = 2;
    localparam int CAUSE_CMON = 3;

    typedef enum logic [2:0] {
        ST_PORWAIT = 3'd0,
        ST_DRIVE   = 3'd1,
        ST_GAP     = 3'd2,
        ST_SAMPLE  = 3'd3,
        ST_HOLD    = 3'd4,
        ST_RUN     = 3'd5
    } seq_state_e;

endpackage

// File: rtl/rst_pad_sync.sv
module rst_pad_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic arst,
    input  logic raw_i,
    output logic sync_o
);
    logic [STAGES-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or posedge arst) begin
                if (arst) chain_q <= '0;
                else      chain_q <= raw_i;
            end
        end else begin : g_multi
            always_ff @(posedge clk or posedge arst) begin
                if (arst) chain_q <= '0;
                else      chain_q <= {chain_q[STAGES-2:0], raw_i};
            end
        end
    endgenerate

    assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/rst_cause_enc.sv
module rst_cause_enc
    import rst_seq_pkg::*;
(
    input  logic               pad_high_i,
    input  logic               src_wdog_i,
    input  logic               src_cmon_i,
    output logic [CAUSE_W-1:0] cause_o
);
    always_comb begin
        cause_o = '0;
        if (!pad_high_i)     cause_o[CAUSE_EXT]  = 1'b1;
        else if (src_wdog_i) cause_o[CAUSE_WDOG] = 1'b1;
        else if (src_cmon_i) cause_o[CAUSE_CMON] = 1'b1;
        else                 cause_o[CAUSE_EXT]  = 1'b1;
    end
endmodule

// File: rtl/rst_seq.sv
module rst_seq
    import rst_seq_pkg::*;
#(
    parameter int POR_CYCLES   = 4064,
    parameter int DRIVE_CYCLES = 4,
    parameter int SAMPLE_GAP   = 2,
    parameter int SYNC_STAGES  = 2
) (
    input  logic               clk,
    input  logic               por_i,
    input  logic               wdog_req_i,
    input  logic               cmon_req_i,
    input  logic               pad_in_i,
    output logic               pad_drive_low_o,
    output logic               core_rst_o,
    output logic [CAUSE_W-1:0] cause_o
);
    localparam int MAX_SPAN = (POR_CYCLES > DRIVE_CYCLES) ?
                              ((POR_CYCLES > SAMPLE_GAP) ? POR_CYCLES : SAMPLE_GAP) :
                              ((DRIVE_CYCLES > SAMPLE_GAP) ? DRIVE_CYCLES : SAMPLE_GAP);
    localparam int CNT_W = $clog2(MAX_SPAN + 1);
    localparam logic [CNT_W-1:0] POR_LAST   = CNT_W'(POR_CYCLES - 1);
    localparam logic [CNT_W-1:0] DRIVE_LAST = CNT_W'(DRIVE_CYCLES - 1);
    localparam logic [CNT_W-1:0] GAP_LAST   = CNT_W'(SAMPLE_GAP - 1);

    typedef struct packed {
        seq_state_e         st;
        logic [CNT_W-1:0]   cnt;
        logic               src_wdog;
        logic               src_cmon;
        logic [CAUSE_W-1:0] cause;
    } seq_reg_t;

    localparam seq_reg_t RESET_VAL = '{
        st:       ST_PORWAIT,
        cnt:      '0,
        src_wdog: 1'b0,
        src_cmon: 1'b0,
        cause:    CAUSE_W'(1) << CAUSE_POR
    };

    seq_reg_t           seq_d, seq_q;
    logic               pad_s;
    logic               any_req;
    logic [CAUSE_W-1:0] cause_new;

    rst_pad_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .arst   (por_i),
        .raw_i  (pad_in_i),
        .sync_o (pad_s)
    );

    rst_cause_enc u_enc (
        .pad_high_i (pad_s),
        .src_wdog_i (seq_q.src_wdog),
        .src_cmon_i (seq_q.src_cmon),
        .cause_o    (cause_new)
    );

    assign any_req = wdog_req_i | cmon_req_i;

    always_comb begin
        seq_d = seq_q;
        unique case (seq_q.st)
            ST_PORWAIT: begin
                if (seq_q.cnt == POR_LAST) begin
                    seq_d.cnt = '0;
                    seq_d.st  = pad_s ? ST_RUN : ST_HOLD;
                end else begin
                    seq_d.cnt = seq_q.cnt + 1'b1;
                end
            end
            ST_DRIVE, ST_GAP, ST_SAMPLE: begin
                if (any_req) begin
                    seq_d.st       = ST_DRIVE;
                    seq_d.cnt      = '0;
                    seq_d.src_wdog = wdog_req_i;
                    seq_d.src_cmon = cmon_req_i & ~wdog_req_i;
                end else if (seq_q.st == ST_DRIVE) begin
                    if (seq_q.cnt == DRIVE_LAST) begin
                        seq_d.st  = ST_GAP;
                        seq_d.cnt = '0;
                    end else begin
                        seq_d.cnt = seq_q.cnt + 1'b1;
                    end
                end else if (seq_q.st == ST_GAP) begin
                    if (seq_q.cnt == GAP_LAST) begin
                        seq_d.st  = ST_SAMPLE;
                        seq_d.cnt = '0;
                    end else begin
                        seq_d.cnt = seq_q.cnt + 1'b1;
                    end
                end else begin
                    seq_d.cause = cause_new;
                    seq_d.st    = pad_s ? ST_RUN : ST_HOLD;
                end
            end
            ST_HOLD: begin
                if (pad_s) seq_d.st = ST_RUN;
            end
            ST_RUN: begin
                if (any_req || !pad_s) begin
                    seq_d.st       = ST_DRIVE;
                    seq_d.cnt      = '0;
                    seq_d.src_wdog = wdog_req_i;
                    seq_d.src_cmon = cmon_req_i & ~wdog_req_i;
                end
            end
            default: seq_d = RESET_VAL;
        endcase
    end

    always_ff @(posedge clk or posedge por_i) begin
        if (por_i) seq_q <= RESET_VAL;
        else       seq_q <= seq_d;
    end

    assign pad_drive_low_o = (seq_q.st == ST_DRIVE);
    assign core_rst_o      = (seq_q.st != ST_RUN);
    assign cause_o         = seq_q.cause;

endmodule

// File: rtl/rst_seq_chk.sv
module rst_seq_chk #(
    parameter int POR_CYCLES = 4064
) (
    input logic       clk,
    input logic       por_i,
    input logic       wdog_req_i,
    input logic       cmon_req_i,
    input logic       pad_sync,
    input logic       pad_drive_low_o,
    input logic       core_rst_o,
    input logic [3:0] cause_o
);
    localparam int PC_W = $clog2(POR_CYCLES + 1);
    logic [PC_W-1:0] since_por;

    always_ff @(posedge clk or posedge por_i) begin
        if (por_i)                              since_por <= '0;
        else if (since_por != PC_W'(POR_CYCLES)) since_por <= since_por + 1'b1;
    end

    // R1
    por_hold_chk: assert property (@(posedge clk) disable iff (por_i)
        (since_por != PC_W'(POR_CYCLES)) |-> core_rst_o);

    // R2
    release_needs_pad_chk: assert property (@(posedge clk) disable iff (por_i)
        $fell(core_rst_o) |-> $past(pad_sync));

    // R4
    drive_in_reset_chk: assert property (@(posedge clk) disable iff (por_i)
        pad_drive_low_o |-> core_rst_o);

    // R4
    req_enters_reset_chk: assert property (@(posedge clk) disable iff (por_i)
        (!core_rst_o && (wdog_req_i || cmon_req_i)) |=> core_rst_o);

    // R10
    cause_onehot_chk: assert property (@(posedge clk) disable iff (por_i)
        $countones(cause_o) == 1);

    // R10
    cause_hold_chk: assert property (@(posedge clk) disable iff (por_i)
        (!core_rst_o && !$past(core_rst_o)) |-> $stable(cause_o));

endmodule

bind rst_seq rst_seq_chk #(.POR_CYCLES(POR_CYCLES)) u_chk (
    .clk             (clk),
    .por_i           (por_i),
    .wdog_req_i      (wdog_req_i),
    .cmon_req_i      (cmon_req_i),
    .pad_sync        (pad_s),
    .pad_drive_low_o (pad_drive_low_o),
    .core_rst_o      (core_rst_o),
    .cause_o         (cause_o)
);

// File: tb/rst_seq_tb.sv
`timescale 1ns/100ps
module rst_seq_tb;
    localparam int NPOR  = 20;
    localparam int NDRV  = 4;
    localparam int NGAP  = 2;
    localparam int NINT  = NDRV + NGAP + 1;

    logic       clk = 1'b0;
    logic       por = 1'b1;
    logic       wdog = 1'b0;
    logic       cmon = 1'b0;
    logic       ext_low = 1'b0;
    logic       pad_drv;
    logic       core_rst;
    logic [3:0] cause;
    logic       pad;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    assign pad = ~(pad_drv | ext_low);

    always #2.5 clk = ~clk;

    rst_seq #(.POR_CYCLES(NPOR), .DRIVE_CYCLES(NDRV), .SAMPLE_GAP(NGAP), .SYNC_STAGES(2)) u_dut (
        .clk             (clk),
        .por_i           (por),
        .wdog_req_i      (wdog),
        .cmon_req_i      (cmon),
        .pad_in_i        (pad),
        .pad_drive_low_o (pad_drv),
        .core_rst_o      (core_rst),
        .cause_o         (cause)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Power-on: pad held low until edge hold_t (0 = free), request pulse at edge req_t (0 = none)
    task automatic por_run(input int hold_t, input int req_t, input string req);
        int t;
        int exp;
        por = 1'b1; ext_low = (hold_t > 0);
        tick(); tick();
        chk(core_rst == 1'b1 && pad_drv == 1'b0 && cause == 4'b0001, "R1 reset state", int'(cause), 1);
        por = 1'b0;
        t = 0;
        while (core_rst && t < 500) begin
            tick(); t++;
            if (t == hold_t) ext_low = 1'b0;
            wdog = (t == req_t);
            cmon = (t == req_t);
        end
        wdog = 1'b0; cmon = 1'b0;
        exp = (hold_t + 3 > NPOR) ? hold_t + 3 : NPOR;
        chk(t == exp, req, t, exp);
        chk(cause == 4'b0001, {req, " cause"}, int'(cause), 1);
    endtask

    // Internal request; returns release distance and drive length
    task automatic int_run(input bit w, input bit c, input logic [3:0] exp_cause, input string req);
        int n;
        int drv;
        wdog = w; cmon = c;
        tick();
        wdog = 1'b0; cmon = 1'b0;
        chk(core_rst == 1'b1, "R4 enter reset", int'(core_rst), 1);
        n = 0; drv = 0;
        while (core_rst && n < 100) begin
            if (pad_drv) drv++;
            tick(); n++;
        end
        chk(drv == NDRV, "R4 drive length", drv, NDRV);
        chk(n == NINT, "R5 release edge", n, NINT);
        chk(cause == exp_cause, req, int'(cause), int'(exp_cause));
        tick(); tick();
    endtask

    initial begin
        tick(); tick();
        // R1: free pad
        por_run(0, 0, "R1 por count");
        tick(); tick();
        // R2: pad held past the count
        por_run(NPOR + 10, 0, "R2 por pad wait");
        tick(); tick();
        // R3: requests inside the count ignored
        por_run(0, 5, "R3 por ignores req");
        tick(); tick();

        int_run(1'b1, 1'b0, 4'b0100, "R6 watchdog cause");
        int_run(1'b0, 1'b1, 4'b1000, "R6 clock monitor cause");
        int_run(1'b1, 1'b1, 4'b0100, "R6 watchdog priority");

        // R8: restart at every offset in drive/gap/sample
        for (int k = 1; k <= NINT; k++) begin
            int n;
            wdog = 1'b1; tick(); wdog = 1'b0;
            for (int j = 1; j < k; j++) tick();
            cmon = 1'b1; tick(); cmon = 1'b0;
            n = 0;
            while (core_rst && n < 100) begin tick(); n++; end
            chk(n == NINT, "R8 restart release", n, NINT);
            chk(cause == 4'b1000, "R8 restart source", int'(cause), 8);
            chk(cause == 4'b1000 && !core_rst, "R10 cause held", int'(cause), 8);
            tick(); tick();
        end

        // R7: external pad low of length L
        for (int L = 1; L <= 16; L++) begin
            int t;
            int exp;
            bit seen;
            ext_low = 1'b1; t = 0; seen = 1'b0;
            while (t < 200) begin
                tick(); t++;
                if (t == L) ext_low = 1'b0;
                if (core_rst) seen = 1'b1;
                else if (seen) break;
            end
            exp = (L + 3 > 10) ? L + 3 : 10;
            chk(t == exp, "R7 external release", t, exp);
            chk(cause == 4'b0010, "R7 external cause", int'(cause), 2);
            tick(); tick();
        end

        // R9: request during the pad wait is ignored
        begin
            int t;
            bit seen;
            ext_low = 1'b1; t = 0; seen = 1'b0;
            while (t < 200) begin
                tick(); t++;
                if (t == 20) ext_low = 1'b0;
                wdog = (t == 14);
                if (core_rst) seen = 1'b1;
                else if (seen) break;
            end
            wdog = 1'b0;
            chk(t == 23, "R9 hold ignores req", t, 23);
            chk(cause == 4'b0010, "R9 hold keeps cause", int'(cause), 2);
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #(5ns * 20000);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule